// File: doc/BRIEF.md
# Pin Level and Change Interrupt Detector

This block watches a small general-purpose I/O port and raises two interrupt requests toward a small processor. One port pin also serves as the external interrupt input. On that pin, a two-bit sense field selects one of four triggers: a low level, any change, a falling edge or a rising edge. In parallel, a pin-change detector raises its own request when any port pin changes value. The pins are first brought into the clock domain by a synchroniser. Edges are then found by comparing each new sample with the previous one.

Each detector still sees a pin while the core drives that pin as an output. Software can therefore raise an interrupt by writing the pin. The top port pin is an exception: it counts for pin-change only while its direction bit marks it as an input. The edge-style requests are sticky and clear on an acknowledge pulse. The low-level request is not stored and follows the pin. A single transition on the external pin can set both requests in the same cycle.

Top module: `pin_irq_unit`

## Requirements
- R1: While reset is asserted, and after reset is released with the pins held steady, `ext_irq_o` and `pc_irq_o` are 0. No spurious change is seen while the sampling chain fills after reset.
- R2: With `ext_sense_i` = 2'b10 (falling edge), a high-to-low transition on port pin `EXT_BIT` (default 2) sets `ext_irq_o`. The change is driven before a clock edge; the request is still 0 after two rising edges and is 1 after the third.
- R3: With `ext_sense_i` = 2'b11 (rising edge), a low-to-high transition on pin `EXT_BIT` sets `ext_irq_o` with the same three-edge latency. A high-to-low transition does not set it.
- R4: With `ext_sense_i` = 2'b01 (any change), both directions of transition on pin `EXT_BIT` set `ext_irq_o`.
- R5: With `ext_sense_i` = 2'b00 (low level) and `ext_en_i` = 1, `ext_irq_o` is 1 whenever the synchronised pin is low. The acknowledge has no effect on it. It returns to 0 two edges after the pin goes high, without any acknowledge.
- R6: A one-cycle pulse on `ext_ack_i` or `pc_ack_i` clears the matching sticky request. If a new detection falls on the same edge as the acknowledge, the request stays set.
- R7: A change on any of port pins 0 to 4 sets `pc_irq_o`, whatever the value of their `port_dir_i` bits (1 = output).
- R8: A change on port pin 5 sets `pc_irq_o` only while `port_dir_i[5]` = 0 (input). With `port_dir_i[5]` = 1, such a change leaves `pc_irq_o` at 0.
- R9: While an enable input is 0, detections for that request are discarded. They are not kept and replayed when the enable returns to 1.
- R10: With both enables set, one transition on pin `EXT_BIT` that matches the sense setting sets `ext_irq_o` and `pc_irq_o` on the same clock edge.
- R11: A pin change held for one full clock period is always detected, even if the pin returns to its old value right after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_pin_i | input | PORT_W | Raw port pin levels; bit EXT_BIT is the external interrupt pin |
| port_dir_i | input | PORT_W | Pin direction, 1 = driven as output |
| ext_en_i | input | 1 | External interrupt enable |
| ext_sense_i | input | 2 | 00 low level, 01 any change, 10 falling, 11 rising |
| ext_ack_i | input | 1 | Acknowledge pulse for the external request |
| pc_en_i | input | 1 | Pin-change interrupt enable |
| pc_ack_i | input | 1 | Acknowledge pulse for the pin-change request |
| ext_irq_o | output | 1 | External interrupt request |
| pc_irq_o | output | 1 | Pin-change interrupt request |

## Verification
The assertions assume that the acknowledge, enable, sense and direction inputs come from the processor's clock domain. They also assume that acknowledges are single-cycle pulses and that any pin value lasts at least one clock. The bench changes every input only on the falling clock edge and holds each random pin pattern for at least one full period. Random phases toggle direction, sense and enables while a bench model follows the same sampling pipeline. Directed cases cover set-versus-acknowledge collisions, the gated top pin and the short-pulse limit.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic         valid_o
);
  localparam int CW   = $clog2(STAGES + 2);
  localparam int FILL = STAGES + 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= pin_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= stg_q[STAGES-1];
      if (cnt_q != CW'(FILL)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cur_o   = stg_q[STAGES-1];
  assign prev_o  = prev_q;
  // compare is meaningful once prev holds a real sample
  assign valid_o = (cnt_q == CW'(FILL));

  a_r11_prev_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_o == $past(cur_o));
endmodule

// File: rtl/ext_detect.sv
module ext_detect
  import pin_irq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cur_i,
  input  logic   prev_i,
  input  logic   valid_i,
  input  logic   en_i,
  input  sense_e sense_i,
  input  logic   ack_i,
  output logic   irq_o
);
  logic det, lvl_req, flag_q;

  always_comb begin
    unique case (sense_i)
      SENSE_ANY:  det = cur_i ^ prev_i;
      SENSE_FALL: det = prev_i & ~cur_i;
      SENSE_RISE: det = cur_i & ~prev_i;
      default:    det = 1'b0;
    endcase
    det = det & valid_i & en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (det)   flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign lvl_req = en_i & valid_i & (sense_i == SENSE_LOW) & ~cur_i;
  assign irq_o   = flag_q | lvl_req;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det && ack_i) |=> flag_q);
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !det) |=> !flag_q);
  a_r9_ext_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);
  a_r5_level_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i == SENSE_LOW && cur_i && !flag_q) |-> !irq_o);
endmodule

// File: rtl/pc_detect.sv
module pc_detect #(
  parameter int          W     = 6,
  parameter logic [W-1:0] GATED = 6'b100000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic         valid_i,
  input  logic [W-1:0] dir_i,
  input  logic         en_i,
  input  logic         ack_i,
  output logic         irq_o
);
  logic [W-1:0] mask;
  logic det, flag_q;

  // gated pins drop out while driven as outputs
  assign mask = ~(dir_i & GATED);
  assign det  = valid_i & en_i & (|((cur_i ^ prev_i) & mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (det)   flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign irq_o = flag_q;

  a_r6_pc_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det && ack_i) |=> flag_q);
  a_r9_pc_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !flag_q) |=> !flag_q);
  a_r8_gated_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cur_i ^ prev_i) & ~GATED) == '0 && (dir_i & GATED) == GATED && !flag_q)
    |=> !flag_q);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int              PORT_W  = 6,
  parameter int              EXT_BIT = 2,
  parameter int              STAGES  = 2,
  parameter logic [PORT_W-1:0] GATED = 6'b100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_pin_i,
  input  logic [PORT_W-1:0] port_dir_i,
  input  logic              ext_en_i,
  input  logic [1:0]        ext_sense_i,
  input  logic              ext_ack_i,
  input  logic              pc_en_i,
  input  logic              pc_ack_i,
  output logic              ext_irq_o,
  output logic              pc_irq_o
);
  logic [PORT_W-1:0] cur, prev;
  logic sync_valid;

  pin_sync_bank #(.W(PORT_W), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(port_pin_i),
    .cur_o(cur), .prev_o(prev), .valid_o(sync_valid)
  );

  ext_detect u_ext (
    .clk_i, .rst_ni,
    .cur_i(cur[EXT_BIT]), .prev_i(prev[EXT_BIT]), .valid_i(sync_valid),
    .en_i(ext_en_i), .sense_i(sense_e'(ext_sense_i)), .ack_i(ext_ack_i),
    .irq_o(ext_irq_o)
  );

  pc_detect #(.W(PORT_W), .GATED(GATED)) u_pc (
    .clk_i, .rst_ni, .cur_i(cur), .prev_i(prev), .valid_i(sync_valid),
    .dir_i(port_dir_i), .en_i(pc_en_i), .ack_i(pc_ack_i), .irq_o(pc_irq_o)
  );

  a_r5_level_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_en_i && ext_sense_i == 2'b00 && sync_valid &&
     !$past(port_pin_i[EXT_BIT], 2)) |-> ext_irq_o);
  a_r1_quiet_warmup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_valid |=> !pc_irq_o);
endmodule

// File: tb/tb_pin_irq_unit.sv
module tb_pin_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int EB = 2;

  logic clk = 0, rst_n = 0;
  logic [5:0] pin = 6'h3F, dir = 6'h00;
  logic ext_en = 1, pc_en = 1, ext_ack = 0, pc_ack = 0;
  logic [1:0] sense = 2'b10;
  logic ext_irq, pc_irq;
  int n_chk = 0, n_fail = 0;
  bit model_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .port_pin_i(pin), .port_dir_i(dir),
    .ext_en_i(ext_en), .ext_sense_i(sense), .ext_ack_i(ext_ack),
    .pc_en_i(pc_en), .pc_ack_i(pc_ack),
    .ext_irq_o(ext_irq), .pc_irq_o(pc_irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_both();
    ext_ack = 1; pc_ack = 1; step(1); ext_ack = 0; pc_ack = 0;
  endtask

  // bench model: two sync stages, a previous sample, warm-up of three edges
  logic [5:0] m1, ms, mp;
  int m_cnt;
  logic m_ext, m_pc;

  function automatic logic edge_hit(input logic [1:0] s, input logic c, input logic p);
    case (s)
      2'b01: return c ^ p;
      2'b10: return p & ~c;
      2'b11: return c & ~p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; ms = 0; mp = 0; m_cnt = 0; m_ext = 0; m_pc = 0;
    end else begin
      logic v, de, dp;
      v  = (m_cnt == 3);
      de = v && ext_en && edge_hit(sense, ms[EB], mp[EB]);
      dp = v && pc_en && (|((ms ^ mp) & ~(dir & 6'b100000)));
      m_ext = de ? 1'b1 : (ext_ack ? 1'b0 : m_ext);
      m_pc  = dp ? 1'b1 : (pc_ack ? 1'b0 : m_pc);
      mp = ms; ms = m1; m1 = pin;
      if (m_cnt < 3) m_cnt++;
    end
  end

  function automatic logic exp_ext_out();
    return m_ext | (ext_en && sense == 2'b00 && !ms[EB] && m_cnt == 3);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(2);
    check(ext_irq, 0, "R1 ext in reset");
    check(pc_irq, 0, "R1 pc in reset");
    rst_n = 1;
    step(6);
    check(ext_irq, 0, "R1 ext after reset");
    check(pc_irq, 0, "R1 pc after reset");

    // R2 falling edge, also R10 both flags
    pin[EB] = 0; step(2);
    check(ext_irq, 0, "R2 latency two edges");
    step(1);
    check(ext_irq, 1, "R2 falling sets");
    check(pc_irq, 1, "R10 pc set together");
    ack_both(); step(1);
    check(ext_irq, 0, "R6 ack clears ext");
    check(pc_irq, 0, "R6 ack clears pc");

    // R3 rising
    sense = 2'b11; pin[EB] = 1; step(3);
    check(ext_irq, 1, "R3 rising sets");
    ack_both(); step(1);
    pin[EB] = 0; step(3);
    check(ext_irq, 0, "R3 falling ignored");
    check(pc_irq, 1, "R7 pc on pin2");
    ack_both(); step(1);

    // R4 any change
    sense = 2'b01; pin[EB] = 1; step(3);
    check(ext_irq, 1, "R4 rise sets");
    ack_both(); step(1);
    pin[EB] = 0; step(3);
    check(ext_irq, 1, "R4 fall sets");
    ack_both(); step(1);

    // R5 low level, pin2 is low
    sense = 2'b00; step(1);
    check(ext_irq, 1, "R5 low asserts");
    ext_ack = 1; step(1); ext_ack = 0;
    check(ext_irq, 1, "R5 ack no effect");
    pin[EB] = 1; step(1);
    check(ext_irq, 1, "R5 still low in sync");
    step(1);
    check(ext_irq, 0, "R5 drops unlatched");
    ack_both(); step(1);

    // R6 set wins over ack
    sense = 2'b10; pin[EB] = 0; step(2);
    ext_ack = 1; step(1); ext_ack = 0;
    check(ext_irq, 1, "R6 set wins");
    ack_both(); step(1);
    check(ext_irq, 0, "R6 cleared after");

    // R7 outputs still seen
    dir = 6'h3F;
    pin[0] = ~pin[0]; step(3);
    check(pc_irq, 1, "R7 pin0 as output");
    ack_both(); step(1);
    pin[4] = ~pin[4]; step(3);
    check(pc_irq, 1, "R7 pin4 as output");
    ack_both(); step(1);

    // R8 gated pin 5
    pin[5] = ~pin[5]; step(5);
    check(pc_irq, 0, "R8 pin5 output ignored");
    dir[5] = 0; step(1);
    pin[5] = ~pin[5]; step(3);
    check(pc_irq, 1, "R8 pin5 input seen");
    ack_both(); step(1);

    // R9 enables off
    pc_en = 0; pin[1] = ~pin[1]; step(4);
    check(pc_irq, 0, "R9 pc disabled");
    pin[EB] = 1; step(4); ack_both(); step(1);
    ext_en = 0; pin[EB] = 0; step(4);
    check(ext_irq, 0, "R9 ext disabled");
    ext_en = 1; pc_en = 1; step(3);
    check(ext_irq, 0, "R9 ext not replayed");
    check(pc_irq, 0, "R9 pc not replayed");

    // R11 one-cycle pulse
    pin[3] = ~pin[3]; step(1); pin[3] = ~pin[3]; step(2);
    check(pc_irq, 1, "R11 short pulse");
    ack_both(); step(3);

    // random phase against the bench model
    model_chk = 1;
    for (int i = 0; i < 4000; i++) begin
      check(ext_irq, exp_ext_out(), "R2 R3 R4 R5 R6 random ext");
      check(pc_irq, m_pc, "R7 R8 R9 random pc");
      if ($urandom_range(3) == 0) pin = pin ^ 6'($urandom_range(63));
      if ($urandom_range(15) == 0) dir = 6'($urandom_range(63));
      if ($urandom_range(31) == 0) sense = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) ext_en = ~ext_en;
      if ($urandom_range(31) == 0) pc_en = ~pc_en;
      ext_ack = ($urandom_range(5) == 0);
      pc_ack  = ($urandom_range(5) == 0);
      step(1);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule